// File: doc/BRIEF.md
# Decade or Binary Clock Prescaler

This block turns one chosen reference rate into four slower tick strobes that counter channels can use as internal count sources. The reference, called the base tick, is picked from four rates. Two rates come from a crystal tick input (one tenth and one half of it). Two come from the system clock itself (one tenth and one twentieth of it). Each rate is produced as a one-cycle enable from a free-running counter, never as a derived clock.

The base tick drives a chain of four stages. A run-time mode bit makes every stage count modulo ten (decade scaling) or modulo sixteen (binary scaling). Tap k therefore fires once per 10^(k+1) base ticks in decade mode, or once per 16^(k+1) base ticks in binary mode.

Any change of the mode bit or of the base select clears the whole chain. Because of this, no tap ever emits a shortened period after reconfiguration. All four strobes come from registers.

Top module: `decbin_prescaler`

## Requirements
- R1: `base_sel` picks the base tick: 0 = every 10th `xtal_tick` pulse, 1 = every 2nd `xtal_tick` pulse, 2 = every 10th system clock cycle, 3 = every 20th system clock cycle.
- R2: With `bin_mode` = 0, `tap_o[k]` for k = 0..3 strobes once every 10, 100, 1000 and 10000 base ticks, evenly spaced.
- R3: With `bin_mode` = 1, `tap_o[k]` for k = 0..3 strobes once every 16, 256, 4096 and 65536 base ticks, evenly spaced.
- R4: Every strobe on any tap lasts exactly one system clock cycle.
- R5: Whenever `tap_o[k]` is high for k > 0, `tap_o[k-1]` is high in the same cycle.
- R6: In the cycle after `base_sel` or `bin_mode` changes, all taps are low. The first `tap_o[0]` strobe after such a change comes only after a full modulus of fresh base ticks.
- R7: While a crystal-derived rate (select 0 or 1) is chosen, no tap strobes in the cycle after a cycle with `xtal_tick` low.
- R8: While `rst` is high and in the first cycle after it, all taps are low, and the chain restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the bus-rate reference |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period, already synchronous to clk |
| base_sel | input | 2 | Base tick source select (R1 encoding) |
| bin_mode | input | 1 | 0 = decade scaling, 1 = binary scaling |
| tap_o | output | NTAPS (4) | Registered one-cycle tick strobes, bit k = k-th tap |

## Verification
On every cycle, the assertions check several rules: the nesting of the taps, the one-cycle width of each strobe, the quiet cycle that follows any reconfiguration, and the absence of strobes when no crystal pulse arrived under a crystal select. The exact tap spacings in both scaling modes can only be shown by the bench's scenarios. So can the select encoding, the latency bounds of the first strobe after a change, and the silence under a stopped crystal. The bench measures these in clock cycles and compares them with base period times the power of the modulus.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL_D10 = 2'd0,
    SRC_XTAL_D2  = 2'd1,
    SRC_SYS_D10  = 2'd2,
    SRC_SYS_D20  = 2'd3
  } src_sel_e;
  localparam int NSRC = 4;
endpackage

// File: rtl/rate_div.sv
module rate_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int DEC_MOD = 10,
  parameter int BIN_MOD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bin_mode,
  input  logic adv,
  output logic wrap
);
  localparam int W = $clog2(BIN_MOD);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last = bin_mode ? W'(BIN_MOD - 1) : W'(DEC_MOD - 1);
  assign wrap = adv && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/decbin_prescaler.sv
module decbin_prescaler
  import prescale_pkg::*;
#(
  parameter int NTAPS    = 4,
  parameter int DEC_MOD  = 10,
  parameter int BIN_MOD  = 16,
  parameter int XDIV_A   = 10,
  parameter int XDIV_B   = 2,
  parameter int SDIV_A   = 10,
  parameter int SDIV_B   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_tick,
  input  logic [1:0]       base_sel,
  input  logic             bin_mode,
  output logic [NTAPS-1:0] tap_o
);
  localparam int DIVS [NSRC] = '{XDIV_A, XDIV_B, SDIV_A, SDIV_B};

  logic [NSRC-1:0]  src_tick;
  logic             base_tick;
  logic [1:0]       sel_q;
  logic             mode_q;
  logic             clr;
  logic [NTAPS:0]   adv;
  logic [NTAPS-1:0] tap_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rate_div #(.DIV(DIVS[g])) u_div (
      .clk  (clk),
      .rst  (rst),
      .en   ((g < 2) ? xtal_tick : 1'b1),
      .tick (src_tick[g])
    );
  end

  assign base_tick = src_tick[src_sel_e'(base_sel)];
  assign clr       = (base_sel != sel_q) || (bin_mode != mode_q);
  assign adv[0]    = base_tick;

  always_ff @(posedge clk) begin
    sel_q  <= base_sel;
    mode_q <= bin_mode;
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    prescale_stage #(.DEC_MOD(DEC_MOD), .BIN_MOD(BIN_MOD)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .bin_mode (bin_mode),
      .adv      (adv[k]),
      .wrap     (adv[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || clr) tap_q <= '0;
    else            tap_q <= adv[NTAPS:1];
  end

  assign tap_o = tap_q;
endmodule

// File: rtl/decbin_prescaler_chk.sv
module decbin_prescaler_chk #(
  parameter int NTAPS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             xtal_tick,
  input logic [1:0]       base_sel,
  input logic             bin_mode,
  input logic [NTAPS-1:0] tap_o
);
  for (genvar i = 1; i < NTAPS; i++) begin : g_nest
    AST_TAP_NEST: assert property (@(posedge clk) disable iff (rst)
      tap_o[i] |-> tap_o[i-1]); // R5
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_width
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      tap_o[i] |=> !tap_o[i]); // R4
  end

  AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (base_sel != $past(base_sel) || bin_mode != $past(bin_mode)) |=> (tap_o == '0)); // R6

  AST_XTAL_GATE: assert property (@(posedge clk) disable iff (rst)
    (!base_sel[1] && !xtal_tick) |=> (tap_o == '0)); // R7

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> (tap_o == '0)); // R8
endmodule

bind decbin_prescaler decbin_prescaler_chk #(.NTAPS(NTAPS)) u_chk (
  .clk(clk), .rst(rst), .xtal_tick(xtal_tick),
  .base_sel(base_sel), .bin_mode(bin_mode), .tap_o(tap_o)
);

// File: tb/decbin_prescaler_test.sv
module decbin_prescaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 180000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xtal_tick = 1'b0;
  logic [1:0] base_sel = 2'd1;
  logic       bin_mode = 1'b0;
  logic [3:0] tap_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t_cfg = 0;
  int xper = 0;
  int xph = 0;

  decbin_prescaler uut (
    .clk(clk), .rst(rst), .xtal_tick(xtal_tick),
    .base_sel(base_sel), .bin_mode(bin_mode), .tap_o(tap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (xper == 0) xtal_tick <= 1'b0;
    else begin
      xtal_tick <= (xph == 0);
      xph <= (xph + 1 >= xper) ? 0 : xph + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setcfg(int sel, bit mode);
    @(negedge clk);
    base_sel = 2'(sel);
    bin_mode = mode;
    t_cfg = cyc;
  endtask

  // R6: first tap0 strobe after a change needs a full modulus of base ticks
  task automatic first_lat(int b, int m);
    int d;
    do @(negedge clk); while (!tap_o[0]);
    d = cyc - t_cfg;
    check(d >= (m - 1) * b + 2 && d <= m * b + 1, "R6 first strobe latency", d, m * b);
  endtask

  // spacing of one tap; also width (R4) and nesting (R5)
  task automatic meas(int ti, int expv, int n, string tag);
    int last;
    do @(negedge clk); while (!tap_o[ti]);
    last = cyc;
    for (int j = 0; j < n; j++) begin
      check((tap_o & ((4'd2 << ti) - 4'd1)) == ((4'd2 << ti) - 4'd1),
            "R5 lower taps high with tap", int'(tap_o), int'((4'd2 << ti) - 4'd1));
      @(negedge clk);
      check(!tap_o[ti], "R4 strobe one cycle", int'(tap_o[ti]), 0);
      while (!tap_o[ti]) @(negedge clk);
      check(cyc - last == expv, tag, cyc - last, expv);
      last = cyc;
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, LIMIT);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(tap_o == 4'd0, "R8 taps low in reset", int'(tap_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(tap_o == 4'd0, "R8 taps low after reset", int'(tap_o), 0);

    // R7: crystal select with no crystal pulses stays silent
    cnt = 0;
    repeat (400) begin
      @(negedge clk);
      if (tap_o != 4'd0) cnt++;
    end
    check(cnt == 0, "R7 no strobes without xtal_tick", cnt, 0);

    xper = 1;
    setcfg(0, 1'b0);
    first_lat(10, 10);
    meas(0, 100, 3, "R1 sel0 xtal/10 decade tap0");
    meas(1, 1000, 1, "R2 sel0 decade tap1");

    setcfg(1, 1'b0);
    first_lat(2, 10);
    meas(0, 20, 3, "R2 sel1 decade tap0");
    meas(1, 200, 2, "R2 sel1 decade tap1");
    meas(2, 2000, 1, "R2 sel1 decade tap2");
    meas(3, 20000, 1, "R2 sel1 decade tap3");

    setcfg(1, 1'b1);
    first_lat(2, 16);
    meas(0, 32, 3, "R3 sel1 binary tap0");
    meas(1, 512, 2, "R3 sel1 binary tap1");
    meas(2, 8192, 1, "R3 sel1 binary tap2");

    setcfg(2, 1'b0);
    first_lat(10, 10);
    meas(0, 100, 2, "R1 sel2 sys/10 decade tap0");
    meas(1, 1000, 1, "R1 sel2 sys/10 decade tap1");

    setcfg(3, 1'b1);
    first_lat(20, 16);
    meas(0, 320, 2, "R1 sel3 sys/20 binary tap0");
    meas(1, 5120, 1, "R3 sel3 binary tap1");

    xper = 3;
    setcfg(1, 1'b0);
    first_lat(6, 10);
    meas(0, 60, 2, "R1 sel1 follows xtal_tick rate");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule